// File: doc/BRIEF.md
# Bus Cycle Watch Comparators

This block watches a CPU bus and raises a one-cycle flag whenever a bus cycle matches a configured pattern. It contains three comparators. The first (A) matches on address plus a data value under a per-bit mask. The second (B) matches on address and can also require a byte or a word access. The third (C) matches on address alone. Each comparator can be restricted to reads, to writes, or accept both. The flags go to a downstream sequencer that decides what to do with them.

Two neighbouring comparators can also be joined into an address window. The lower comparator's reference address is the inclusive lower bound and the upper one's is the inclusive upper bound. The window can fire for addresses inside the bounds or outside them. While a window is active, its two member comparators stop reporting individual matches.

All reference values, the mask and the control fields are loaded through a single write-only register port.

Top module: `buswatch_cmp`

## Requirements
- R1: Comparator A flags a cycle only when the bus address equals its reference address and every data bit whose mask bit is 1 equals the reference data bit. The register indices are: A address 0, A control 4, reference data 8, data mask 9.
- R2: A data bit whose mask bit is 0 never blocks a match on A, whatever its value.
- R3: Comparators B (address index 1, control index 5) and C (address index 2, control index 6) ignore the data bus entirely.
- R4: Control bits [2:1] select the access direction. 1 means reads only (bus_rd=1). 2 means writes only. 0 or 3 means either direction.
- R5: On B only, control bit 3 set requires bus_word to equal control bit 4. With bit 3 clear, access size does not matter.
- R6: Window register (index 12) mode bits [1:0]=1 select inside mode. In inside mode hit_win fires when lower ≤ address ≤ upper, with both bounds inclusive.
- R7: Window mode 2 selects outside mode. In outside mode hit_win fires when address < lower or address > upper. Modes 0 and 3 turn the window off.
- R8: While the window is on, both member comparators of the selected pair never flag individually.
- R9: A match is only evaluated on a cycle where bus_vld is 1. The flag appears on the next cycle and lasts exactly one cycle per valid bus cycle.
- R10: A comparator whose control bit 0 (enable) is clear never flags. The window fires only if both of its members are enabled. The window takes its direction setting from the lower member.
- R11: After reset, all registers are zero and no flag is raised.
- R12: Window register bit 2 selects the pair. With bit 2 clear the pair is A (lower) and B (upper). With bit 2 set the pair is B (lower) and C (upper). The comparator left outside the pair keeps working on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Register index |
| cfg_wdata | input | max(ADDR_W,DATA_W) | Register write data |
| bus_vld | input | 1 | Bus cycle valid |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_rd | input | 1 | 1 for a read, 0 for a write |
| bus_word | input | 1 | 1 for a word access, 0 for a byte access |
| hit_a | output | 1 | Comparator A match pulse |
| hit_b | output | 1 | Comparator B match pulse |
| hit_c | output | 1 | Comparator C match pulse |
| hit_win | output | 1 | Window match pulse |

## Verification
Corrupted internal state, such as a mis-latched reference, a mask bit stuck high or a wrong pair selection, shows up one cycle after the first valid bus cycle that touches it. It appears as a missing or extra pulse on one hit output. The bench therefore compares all four hit outputs on every cycle against a model, so a fault is reported at the cycle it first becomes visible. Range faults only show at the bounds, so addresses at each bound and one step beyond it are driven deliberately.

// File: rtl/buswatch_pkg.sv
package buswatch_pkg;

   localparam int NUM_CMP = 3;

   typedef enum logic [1:0] {
      DIR_EITHER     = 2'd0,
      DIR_READ       = 2'd1,
      DIR_WRITE      = 2'd2,
      DIR_EITHER_ALT = 2'd3
   } dir_sel_e;

   typedef enum logic [1:0] {
      WIN_OFF     = 2'd0,
      WIN_INSIDE  = 2'd1,
      WIN_OUTSIDE = 2'd2,
      WIN_OFF_ALT = 2'd3
   } win_mode_e;

   // bit0 enable, [2:1] direction, bit3 size check, bit4 expected size (1 = word)
   typedef struct packed {
      logic     size_word;
      logic     size_chk;
      dir_sel_e dir;
      logic     en;
   } cmp_ctl_t;

   // bit2 pair select, [1:0] mode
   typedef struct packed {
      logic      pair_hi;
      win_mode_e mode;
   } win_ctl_t;

   localparam int CTL_W = $bits(cmp_ctl_t);
   localparam int WIN_W = $bits(win_ctl_t);

   localparam int REG_ADDR_BASE = 0;
   localparam int REG_CTL_BASE  = 4;
   localparam int REG_DATA      = 8;
   localparam int REG_MASK      = 9;
   localparam int REG_WIN       = 12;

   function automatic logic dir_pass(input dir_sel_e d, input logic rd);
      case (d)
         DIR_READ:  return rd;
         DIR_WRITE: return !rd;
         default:   return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/bw_cfg_regs.sv
module bw_cfg_regs
   import buswatch_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 4,
   parameter int CFG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [ADDR_W-1:0] ref_addr [NUM_CMP],
   output cmp_ctl_t          ctl      [NUM_CMP],
   output logic [DATA_W-1:0] ref_data,
   output logic [DATA_W-1:0] data_mask,
   output win_ctl_t          win_ctl
);

   localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(REG_DATA);
   localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'(REG_MASK);
   localparam logic [SEL_W-1:0] SEL_WIN  = SEL_W'(REG_WIN);

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_regs
         localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(REG_ADDR_BASE + i);
         localparam logic [SEL_W-1:0] SEL_CTL  = SEL_W'(REG_CTL_BASE + i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_addr[i] <= '0;
               ctl[i]      <= '0;
            end else if (cfg_we) begin
               if (cfg_sel == SEL_ADDR) ref_addr[i] <= cfg_wdata[ADDR_W-1:0];
               if (cfg_sel == SEL_CTL)  ctl[i]      <= cmp_ctl_t'(cfg_wdata[CTL_W-1:0]);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_data  <= '0;
         data_mask <= '0;
         win_ctl   <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_DATA) ref_data  <= cfg_wdata[DATA_W-1:0];
         if (cfg_sel == SEL_MASK) data_mask <= cfg_wdata[DATA_W-1:0];
         if (cfg_sel == SEL_WIN)  win_ctl   <= win_ctl_t'(cfg_wdata[WIN_W-1:0]);
      end
   end

   generate
      if (CFG_W > ADDR_W || CFG_W > DATA_W) begin : g_wide_cfg
         wire unused_cfg_hi = ^cfg_wdata;
      end
   endgenerate

endmodule

// File: rtl/bw_point_unit.sv
module bw_point_unit
   import buswatch_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b0,
   parameter bit HAS_SIZE = 1'b0
) (
   input  logic [ADDR_W-1:0] ref_addr,
   input  cmp_ctl_t          ctl,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [DATA_W-1:0] data_mask,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              bus_word,
   output logic              qual,
   output logic              hit
);

   logic addr_eq;
   logic data_ok;
   logic size_ok;

   assign qual    = ctl.en && dir_pass(ctl.dir, bus_rd);
   assign addr_eq = (bus_addr == ref_addr);

   generate
      if (HAS_DATA) begin : g_data
         assign data_ok = (((bus_data ^ ref_data) & data_mask) == '0);
      end else begin : g_no_data
         assign data_ok = 1'b1;
         wire unused_data = ^{ref_data, data_mask, bus_data};
      end

      if (HAS_SIZE) begin : g_size
         assign size_ok = !ctl.size_chk || (bus_word == ctl.size_word);
      end else begin : g_no_size
         assign size_ok = 1'b1;
         wire unused_size = ^{ctl.size_chk, ctl.size_word, bus_word};
      end
   endgenerate

   assign hit = qual && addr_eq && data_ok && size_ok;

endmodule

// File: rtl/bw_window_unit.sv
module bw_window_unit
   import buswatch_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  win_mode_e         mode,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              lo_qual,
   input  logic              hi_en,
   output logic              active,
   output logic              hit
);

   logic above_lo;
   logic below_hi;
   logic in_range;
   logic cond;

   assign active   = (mode == WIN_INSIDE) || (mode == WIN_OUTSIDE);
   assign above_lo = (bus_addr >= lo);
   assign below_hi = (bus_addr <= hi);
   assign in_range = above_lo && below_hi;
   assign cond     = (mode == WIN_INSIDE) ? in_range : !in_range;
   assign hit      = active && lo_qual && hi_en && cond;

endmodule

// File: rtl/buswatch_cmp.sv
module buswatch_cmp
   import buswatch_pkg::*;
#(
   parameter  int ADDR_W = 16,
   parameter  int DATA_W = 16,
   parameter  int SEL_W  = 4,
   localparam int CFG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              bus_vld,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              bus_word,
   output logic              hit_a,
   output logic              hit_b,
   output logic              hit_c,
   output logic              hit_win
);

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
         $error("buswatch_cmp: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("buswatch_cmp: DATA_W out of range");
      end
      if ((1 << SEL_W) <= REG_WIN) begin : g_bad_sel_w
         $error("buswatch_cmp: SEL_W too narrow for register map");
      end
      if (CFG_W < CTL_W) begin : g_bad_cfg_w
         $error("buswatch_cmp: write data narrower than control field");
      end
   endgenerate

   logic [ADDR_W-1:0] ref_addr [NUM_CMP];
   cmp_ctl_t          ctl      [NUM_CMP];
   logic [DATA_W-1:0] ref_data;
   logic [DATA_W-1:0] data_mask;
   win_ctl_t          win_ctl;

   logic [NUM_CMP-1:0] qual;
   logic [NUM_CMP-1:0] ind_hit;
   logic [NUM_CMP-1:0] en_vec;
   logic [NUM_CMP-1:0] mute;
   logic [NUM_CMP-1:0] hit_q;

   logic [ADDR_W-1:0] win_lo;
   logic [ADDR_W-1:0] win_hi;
   logic              win_lo_qual;
   logic              win_hi_en;
   logic              win_active;
   logic              win_hit;
   logic              win_q;

   bw_cfg_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .CFG_W  (CFG_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .ref_addr  (ref_addr),
      .ctl       (ctl),
      .ref_data  (ref_data),
      .data_mask (data_mask),
      .win_ctl   (win_ctl)
   );

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_point
         bw_point_unit #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .HAS_DATA (i == 0),
            .HAS_SIZE (i == 1)
         ) u_pt (
            .ref_addr  (ref_addr[i]),
            .ctl       (ctl[i]),
            .ref_data  (ref_data),
            .data_mask (data_mask),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_rd    (bus_rd),
            .bus_word  (bus_word),
            .qual      (qual[i]),
            .hit       (ind_hit[i])
         );

         assign en_vec[i] = ctl[i].en;

         // member of the pair: A,B when pair_hi=0; B,C when pair_hi=1
         if (i == 1) begin : g_mute_mid
            assign mute[i] = win_active;
         end else if (i == 0) begin : g_mute_lo
            assign mute[i] = win_active && !win_ctl.pair_hi;
         end else begin : g_mute_hi
            assign mute[i] = win_active && win_ctl.pair_hi;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q[i] <= 1'b0;
            else        hit_q[i] <= bus_vld && ind_hit[i] && !mute[i];
         end
      end
   endgenerate

   assign win_lo      = win_ctl.pair_hi ? ref_addr[1] : ref_addr[0];
   assign win_hi      = win_ctl.pair_hi ? ref_addr[2] : ref_addr[1];
   assign win_lo_qual = win_ctl.pair_hi ? qual[1]     : qual[0];
   assign win_hi_en   = win_ctl.pair_hi ? en_vec[2]   : en_vec[1];

   bw_window_unit #(
      .ADDR_W (ADDR_W)
   ) u_win (
      .mode     (win_ctl.mode),
      .lo       (win_lo),
      .hi       (win_hi),
      .bus_addr (bus_addr),
      .lo_qual  (win_lo_qual),
      .hi_en    (win_hi_en),
      .active   (win_active),
      .hit      (win_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= 1'b0;
      else        win_q <= bus_vld && win_hit;
   end

   assign hit_a   = hit_q[0];
   assign hit_b   = hit_q[1];
   assign hit_c   = hit_q[2];
   assign hit_win = win_q;

endmodule

// File: rtl/buswatch_cmp_chk.sv
module buswatch_cmp_chk
   import buswatch_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_vld,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              hit_a,
   input logic              hit_b,
   input logic              hit_c,
   input logic              hit_win,
   input logic [2:0]        en_vec,
   input win_ctl_t          wctl,
   input logic [ADDR_W-1:0] lo,
   input logic [ADDR_W-1:0] hi
);

   assert_pulse_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a || hit_b || hit_c || hit_win) |-> $past(bus_vld));

   assert_disabled_a_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |-> $past(en_vec[0]));

   assert_disabled_b_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b |-> $past(en_vec[1]));

   assert_disabled_c_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |-> $past(en_vec[2]));

   assert_pair_ab_muted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past((wctl.mode == WIN_INSIDE || wctl.mode == WIN_OUTSIDE) && !wctl.pair_hi)
      |-> (!hit_a && !hit_b));

   assert_pair_bc_muted_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past((wctl.mode == WIN_INSIDE || wctl.mode == WIN_OUTSIDE) && wctl.pair_hi)
      |-> (!hit_b && !hit_c));

   assert_inside_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_win && $past(wctl.mode) == WIN_INSIDE)
      |-> ($past(bus_addr) >= $past(lo) && $past(bus_addr) <= $past(hi)));

   assert_outside_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_win && $past(wctl.mode) == WIN_OUTSIDE)
      |-> ($past(bus_addr) < $past(lo) || $past(bus_addr) > $past(hi)));

endmodule

bind buswatch_cmp buswatch_cmp_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_vld  (bus_vld),
   .bus_addr (bus_addr),
   .hit_a    (hit_a),
   .hit_b    (hit_b),
   .hit_c    (hit_c),
   .hit_win  (hit_win),
   .en_vec   (en_vec),
   .wctl     (win_ctl),
   .lo       (win_lo),
   .hi       (win_hi)
);

// File: tb/buswatch_cmp_test.sv
`timescale 1ns/1ps
module buswatch_cmp_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        bus_vld = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic        bus_rd = 1'b0;
   logic        bus_word = 1'b0;
   logic        hit_a, hit_b, hit_c, hit_win;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] s_addr [3];
   logic [4:0]  s_ctl  [3];
   logic [15:0] s_data = '0;
   logic [15:0] s_mask = '0;
   logic [2:0]  s_win  = '0;

   always #2 clk = ~clk;

   buswatch_cmp uut (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
      .bus_vld (bus_vld), .bus_addr (bus_addr), .bus_data (bus_data),
      .bus_rd (bus_rd), .bus_word (bus_word),
      .hit_a (hit_a), .hit_b (hit_b), .hit_c (hit_c), .hit_win (hit_win)
   );

   function automatic logic dir_ok(input logic [4:0] c, input logic rd);
      if (c[2:1] == 2'd1) return rd;
      if (c[2:1] == 2'd2) return !rd;
      return 1'b1;
   endfunction

   // returns {win, c, b, a}
   function automatic logic [3:0] model(input logic v, input logic [15:0] a,
                                        input logic [15:0] d, input logic rd, input logic w);
      logic ea, eb, ec, ew, act, cond;
      logic [15:0] lo, hi;
      logic [4:0] cl, ch;
      ea = s_ctl[0][0] && dir_ok(s_ctl[0], rd) && a == s_addr[0] && (((d ^ s_data) & s_mask) == 16'h0);
      eb = s_ctl[1][0] && dir_ok(s_ctl[1], rd) && a == s_addr[1] && (!s_ctl[1][3] || w == s_ctl[1][4]);
      ec = s_ctl[2][0] && dir_ok(s_ctl[2], rd) && a == s_addr[2];
      act = (s_win[1:0] == 2'd1) || (s_win[1:0] == 2'd2);
      lo = s_win[2] ? s_addr[1] : s_addr[0];
      hi = s_win[2] ? s_addr[2] : s_addr[1];
      cl = s_win[2] ? s_ctl[1] : s_ctl[0];
      ch = s_win[2] ? s_ctl[2] : s_ctl[1];
      cond = (a >= lo && a <= hi);
      if (s_win[1:0] == 2'd2) cond = !cond;
      ew = act && cl[0] && dir_ok(cl, rd) && ch[0] && cond;
      if (act) begin
         if (!s_win[2]) begin ea = 1'b0; eb = 1'b0; end
         else           begin eb = 1'b0; ec = 1'b0; end
      end
      return v ? {ew, ec, eb, ea} : 4'b0000;
   endfunction

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [15:0] val);
      cfg_we = 1'b1; cfg_sel = 4'(idx); cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx <= 2) s_addr[idx] = val;
      else if (idx >= 4 && idx <= 6) s_ctl[idx-4] = val[4:0];
      else if (idx == 8) s_data = val;
      else if (idx == 9) s_mask = val;
      else if (idx == 12) s_win = val[2:0];
   endtask

   task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] d,
                      input logic rd, input logic w, input string tag);
      logic [3:0] e;
      bus_vld = v; bus_addr = a; bus_data = d; bus_rd = rd; bus_word = w;
      e = model(v, a, d, rd, w);
      @(negedge clk);
      chk(tag, "hit_a", hit_a, e[0]);
      chk(tag, "hit_b", hit_b, e[1]);
      chk(tag, "hit_c", hit_c, e[2]);
      chk(tag, "hit_win", hit_win, e[3]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) begin s_addr[i] = '0; s_ctl[i] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R11", "hit_a", hit_a, 1'b0);
      chk("R11", "hit_win", hit_win, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: everything zero, disabled; address 0 equals reset reference yet no flag
      cyc(1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1, "R11");

      // R1 / R2: A with masked data
      wr(0, 16'h1234); wr(8, 16'hAB00); wr(9, 16'hFF00); wr(4, 16'h0001);
      cyc(1'b1, 16'h1234, 16'hABCD, 1'b1, 1'b0, "R2");
      cyc(1'b1, 16'h1234, 16'hAC00, 1'b1, 1'b0, "R1");
      cyc(1'b1, 16'h1235, 16'hAB00, 1'b1, 1'b0, "R1");
      // R9: no valid -> nothing; a pulse lasts one cycle
      cyc(1'b0, 16'h1234, 16'hAB00, 1'b1, 1'b0, "R9");
      cyc(1'b1, 16'h1234, 16'hAB11, 1'b0, 1'b0, "R9");
      cyc(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, "R9");

      // R4: direction qualifiers
      wr(4, 16'h0003);
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b0, 1'b0, "R4");
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b1, 1'b0, "R4");
      wr(4, 16'h0005);
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b1, 1'b0, "R4");
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b0, 1'b0, "R4");
      wr(4, 16'h0007);
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b1, 1'b0, "R4");

      // R10: disable A
      wr(4, 16'h0000);
      cyc(1'b1, 16'h1234, 16'hAB00, 1'b1, 1'b0, "R10");

      // R5: B size qualifier, R3: B/C ignore data
      wr(1, 16'h2000); wr(5, 16'h0019);
      cyc(1'b1, 16'h2000, 16'h5555, 1'b1, 1'b1, "R5");
      cyc(1'b1, 16'h2000, 16'h5555, 1'b1, 1'b0, "R5");
      wr(5, 16'h0009);
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b0, "R5");
      wr(5, 16'h0001);
      cyc(1'b1, 16'h2000, 16'hFFFF, 1'b0, 1'b1, "R3");
      cyc(1'b1, 16'h2000, 16'h0000, 1'b0, 1'b0, "R3");
      wr(2, 16'h3000); wr(6, 16'h0001);
      cyc(1'b1, 16'h3000, 16'h9876, 1'b1, 1'b0, "R3");
      cyc(1'b1, 16'h3000, 16'h0123, 1'b0, 1'b1, "R3");

      // R6: inside window A..B inclusive, R8: members muted
      wr(0, 16'h1000); wr(4, 16'h0001); wr(8, 16'h0000); wr(9, 16'h0000); wr(1, 16'h1FFF);
      wr(12, 16'h0001);
      cyc(1'b1, 16'h1000, 16'h0000, 1'b1, 1'b0, "R6");
      cyc(1'b1, 16'h1FFF, 16'h0000, 1'b1, 1'b0, "R6");
      cyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b0, "R6");
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b0, "R6");
      cyc(1'b1, 16'h1000, 16'h0000, 1'b0, 1'b1, "R8");
      // R7: outside
      wr(12, 16'h0002);
      cyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b0, "R7");
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b0, "R7");
      cyc(1'b1, 16'h1500, 16'h0000, 1'b1, 1'b0, "R7");
      cyc(1'b1, 16'h1000, 16'h0000, 1'b1, 1'b0, "R7");
      // R10: window needs both members enabled; direction from lower member
      wr(5, 16'h0000);
      cyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b0, "R10");
      wr(5, 16'h0001); wr(4, 16'h0005);
      cyc(1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b0, "R10");
      cyc(1'b1, 16'h0FFF, 16'h0000, 1'b0, 1'b0, "R10");
      wr(4, 16'h0001);
      // R12: pair B..C, A keeps working
      wr(12, 16'h0005);
      cyc(1'b1, 16'h2500, 16'h0000, 1'b1, 1'b0, "R12");
      cyc(1'b1, 16'h1500, 16'h0000, 1'b1, 1'b0, "R12");
      cyc(1'b1, 16'h1000, 16'h0000, 1'b1, 1'b0, "R12");
      cyc(1'b1, 16'h3000, 16'h0000, 1'b1, 1'b0, "R8");
      wr(12, 16'h0003);
      cyc(1'b1, 16'h3000, 16'h0000, 1'b1, 1'b0, "R7");

      // constrained random
      for (int r = 0; r < 40; r++) begin
         for (int i = 0; i < 3; i++) begin
            wr(i, 16'($urandom_range(16'h0100, 16'h0140)));
            wr(4 + i, 16'($urandom_range(0, 31) | (($urandom_range(0, 3) != 0) ? 1 : 0)));
         end
         wr(8, 16'($urandom));
         wr(9, 16'($urandom));
         wr(12, 16'($urandom_range(0, 7)));
         for (int k = 0; k < 20; k++) begin
            logic [15:0] a, d;
            int pick;
            pick = $urandom_range(0, 5);
            if (pick < 3) a = s_addr[pick];
            else if (pick == 3) a = s_addr[$urandom_range(0, 2)] + 16'd1;
            else if (pick == 4) a = s_addr[$urandom_range(0, 2)] - 16'd1;
            else a = 16'($urandom_range(16'h00F0, 16'h0150));
            d = ($urandom_range(0, 1) == 1) ? (s_data ^ (16'($urandom) & ~s_mask)) : 16'($urandom);
            cyc(($urandom_range(0, 3) != 0), a, d, 1'($urandom), 1'($urandom), "R1");
         end
      end

      bus_vld = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule